// File: doc/BRIEF.md
# CPU Instruction-Injection Memory Access Controller

This block lets an outside controller read and write the memory and memory-mapped I/O of an 8-bit 65C02-style CPU without owning the CPU's address bus. It works only through the CPU's data bus. One CPU clock cycle at a time, it presents bytes that the CPU takes as instruction fetches. The CPU then produces the real address itself and performs the real load or store. Memory is kept off the bus while these made-up bytes are presented. Memory is let back onto the bus only on the one cycle where the real access happens.

A command port takes an operation code, a 16-bit target address and a write byte, but only while the block is idle. The block follows the CPU clock's falling edges, which it detects from the sampled CPU clock level on `cpu_phi`. It puts the bytes of the operation on the bus. For a read, it captures the byte on the bus at the end of the access cycle. It then pulses `done` for one clock.

The CPU program counter keeps advancing while bytes are injected, so the block never relies on it. A jump operation is provided to put the program counter back where the user wants it afterwards.

Top module: `inject_bus_master`

## Requirements
- R1: After reset, `bus_drive`, `mem_oe` and `done` are 0, `bus_out` and `rdata` are 0x00, and `cmd_ready` is 1.
- R2: A write command (`cmd_op` = 0) drives five CPU cycles with `bus_drive` = 1 and `bus_out` in this order: 0xA9, the write byte, 0x8D, address bits 7:0, address bits 15:8.
- R3: The sixth CPU cycle of a write has `bus_drive` = 0 and `mem_oe` = 0, so the CPU's store reaches memory.
- R4: A read command (`cmd_op` = 1) drives three CPU cycles with 0xAD, address bits 7:0, address bits 15:8. Its fourth cycle has `bus_drive` = 0 and `mem_oe` = 1.
- R5: `rdata` takes the value of `bus_in` at the CPU clock fall that ends a read's fourth cycle. `rdata` holds that value until the next read completes and changes at no other time.
- R6: A jump command (`cmd_op` = 2) drives three CPU cycles with 0x4C, address bits 7:0, address bits 15:8. It ends at the next CPU clock fall with no release cycle.
- R7: `mem_oe` is never 1 while `bus_drive` is 1, and it is 1 only on the access cycle of a read.
- R8: `cmd_ready` is 1 only while idle. A command presented while busy is ignored and does not change the running sequence.
- R9: `cmd_op` = 3 is ignored: the block stays idle and does not drive the bus.
- R10: `done` is a one-clock pulse, raised together with `cmd_ready`, at the CPU clock fall that ends the last cycle of an operation.
- R11: Bus bytes change only at a CPU clock fall. A fall is a clock edge where `cpu_phi` is sampled 0 after being sampled 1. The first byte appears at the first fall after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_phi | input | 1 | CPU clock level, sampled on `clk` |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 write, 1 read, 2 jump, 3 ignored |
| cmd_addr | input | 16 | Target address or jump destination |
| cmd_wdata | input | 8 | Byte to store for a write |
| cmd_ready | output | 1 | Idle, command is taken this clock |
| bus_in | input | 8 | CPU data bus as seen by the block |
| bus_out | output | 8 | Byte to present on the CPU data bus |
| bus_drive | output | 1 | Output enable for `bus_out` |
| mem_oe | output | 1 | Memory output enable, active high |
| done | output | 1 | One-clock end-of-operation pulse |
| rdata | output | 8 | Last captured read byte |

## Verification
The assertions assume that `cpu_phi` stays at each level for at least one system clock. They also assume that a command, once taken, is not counted on to be repeated. The stimulus holds `cpu_phi` high for two clocks and low for two or more, and raises `cmd_valid` only for single clocks. The bench drives `bus_in` from memory while `mem_oe` is high and echoes `bus_out` otherwise, so read capture sees a known byte. It also presents commands during busy phases and uses the unused operation code to check that they are ignored.

// File: rtl/inj_pkg.sv
package inj_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;

    typedef enum logic [1:0] {
        OP_WR   = 2'd0,
        OP_RD   = 2'd1,
        OP_JMP  = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ARMED  = 2'd1,
        PH_FAKE   = 2'd2,
        PH_ACCESS = 2'd3
    } phase_e;

    localparam logic [DATA_W-1:0] OPC_LDA_IMM = 8'hA9;
    localparam logic [DATA_W-1:0] OPC_STA_ABS = 8'h8D;
    localparam logic [DATA_W-1:0] OPC_LDA_ABS = 8'hAD;
    localparam logic [DATA_W-1:0] OPC_JMP_ABS = 8'h4C;

    // number of injected bytes per operation
    function automatic logic [IDX_W-1:0] fake_len(op_e op);
        case (op)
            OP_WR:   fake_len = 3'd5;
            default: fake_len = 3'd3;
        endcase
    endfunction
endpackage

// File: rtl/inj_edge_det.sv
module inj_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= level;
    end

    assign fall = lvl_q & ~level;
endmodule

// File: rtl/inj_byte_sel.sv
module inj_byte_sel
    import inj_pkg::*;
(
    input  op_e               op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] byte_o
);
    logic [DATA_W-1:0] lo, hi;
    assign lo = addr[DATA_W-1:0];
    assign hi = addr[ADDR_W-1:DATA_W];

    always_comb begin
        byte_o = '0;
        case (op)
            OP_WR: begin
                case (idx)
                    3'd0:    byte_o = OPC_LDA_IMM;
                    3'd1:    byte_o = wdata;
                    3'd2:    byte_o = OPC_STA_ABS;
                    3'd3:    byte_o = lo;
                    3'd4:    byte_o = hi;
                    default: byte_o = '0;
                endcase
            end
            OP_RD, OP_JMP: begin
                case (idx)
                    3'd0:    byte_o = (op == OP_RD) ? OPC_LDA_ABS : OPC_JMP_ABS;
                    3'd1:    byte_o = lo;
                    3'd2:    byte_o = hi;
                    default: byte_o = '0;
                endcase
            end
            default: byte_o = '0;
        endcase
    end
endmodule

// File: rtl/inject_bus_master.sv
module inject_bus_master
    import inj_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_phi,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_addr,
    input  logic [7:0]  cmd_wdata,
    output logic        cmd_ready,
    input  logic [7:0]  bus_in,
    output logic [7:0]  bus_out,
    output logic        bus_drive,
    output logic        mem_oe,
    output logic        done,
    output logic [7:0]  rdata
);
    typedef struct packed {
        phase_e             phase;
        logic [IDX_W-1:0]   idx;
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
        logic               done;
    } st_t;

    st_t st_d, st_q;
    logic fall;
    logic [DATA_W-1:0] sel_byte;
    logic [IDX_W-1:0]  last_idx;

    inj_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (cpu_phi),
        .fall  (fall)
    );

    inj_byte_sel u_sel (
        .op     (st_q.op),
        .idx    (st_q.idx),
        .addr   (st_q.addr),
        .wdata  (st_q.wdata),
        .byte_o (sel_byte)
    );

    assign last_idx = fake_len(st_q.op) - 3'd1;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (cmd_valid && op_e'(cmd_op) != OP_NONE) begin
                    st_d.phase = PH_ARMED;
                    st_d.op    = op_e'(cmd_op);
                    st_d.addr  = cmd_addr;
                    st_d.wdata = cmd_wdata;
                    st_d.idx   = '0;
                end
            end
            PH_ARMED: begin
                if (fall) begin
                    st_d.phase = PH_FAKE;
                    st_d.idx   = '0;
                end
            end
            PH_FAKE: begin
                if (fall) begin
                    if (st_q.idx == last_idx) begin
                        if (st_q.op == OP_JMP) begin
                            st_d.phase = PH_IDLE;
                            st_d.done  = 1'b1;
                        end else begin
                            st_d.phase = PH_ACCESS;
                        end
                    end else begin
                        st_d.idx = st_q.idx + 3'd1;
                    end
                end
            end
            PH_ACCESS: begin
                if (fall) begin
                    if (st_q.op == OP_RD) st_d.rdata = bus_in;
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, op: OP_WR, addr: '0,
                      wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready = (st_q.phase == PH_IDLE);
    assign bus_drive = (st_q.phase == PH_FAKE);
    assign bus_out   = bus_drive ? sel_byte : '0;
    assign mem_oe    = (st_q.phase == PH_ACCESS) && (st_q.op == OP_RD);
    assign done      = st_q.done;
    assign rdata     = st_q.rdata;
endmodule

// File: rtl/inj_access_chk.sv
module inj_access_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_phi,
    input logic [7:0] bus_out,
    input logic       bus_drive,
    input logic       mem_oe,
    input logic       done,
    input logic       cmd_ready,
    input logic [7:0] rdata
);
    logic phi_seen;
    logic fall_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) phi_seen <= 1'b0;
        else        phi_seen <= cpu_phi;
    end
    assign fall_seen = phi_seen & ~cpu_phi;

    // R7
    drive_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_drive && mem_oe));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive || mem_oe) |-> !cmd_ready);

    // R11
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_drive && !fall_seen) |=> (bus_drive && $stable(bus_out)));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done);

    // R7
    oe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_oe && fall_seen) |=> (!mem_oe && done));
endmodule

bind inject_bus_master inj_access_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_phi   (cpu_phi),
    .bus_out   (bus_out),
    .bus_drive (bus_drive),
    .mem_oe    (mem_oe),
    .done      (done),
    .cmd_ready (cmd_ready),
    .rdata     (rdata)
);

// File: tb/sim_inject_bus_master.sv
`timescale 1ns/1ps
module sim_inject_bus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_phi = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_wdata = 8'h0;
    logic        cmd_ready;
    logic [7:0]  bus_in;
    logic [7:0]  bus_out;
    logic        bus_drive;
    logic        mem_oe;
    logic        done;
    logic [7:0]  rdata;
    logic [7:0]  mem_val = 8'h0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] exp_rd = 8'h00;

    always #2 clk = ~clk;

    // memory answers only when enabled; otherwise the bus carries the injected byte
    assign bus_in = mem_oe ? mem_val : (bus_drive ? bus_out : 8'hFF);

    inject_bus_master u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(!(bus_drive && mem_oe), "R7 drive/oe overlap", {bus_drive, mem_oe}, 0);
        end
    end

    // one CPU cycle: high two clocks, then low; returns just after the fall is registered
    task automatic fall_step();
        @(negedge clk) cpu_phi = 1'b1;
        @(negedge clk);
        @(negedge clk) cpu_phi = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_op(input logic [1:0] op, input logic [15:0] addr,
                         input logic [7:0] wd, input logic [7:0] rv, input bit poke);
        logic [7:0] q[$];
        string tag;
        case (op)
            2'd0: begin q = '{8'hA9, wd, 8'h8D, addr[7:0], addr[15:8]}; tag = "R2"; end
            2'd1: begin q = '{8'hAD, addr[7:0], addr[15:8]}; tag = "R4"; end
            default: begin q = '{8'h4C, addr[7:0], addr[15:8]}; tag = "R6"; end
        endcase
        mem_val = rv;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R8 ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R8 busy after accept", cmd_ready, 0);
        if (poke) begin
            cmd_op = 2'd1; cmd_addr = 16'hFFFF;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(bus_drive == 1'b0, "R11 no byte before first fall", bus_drive, 0);
        while (q.size() > 0) begin
            logic [7:0] b;
            b = q.pop_front();
            fall_step();
            chk(bus_drive == 1'b1, {tag, " drive"}, bus_drive, 1);
            chk(bus_out == b, {tag, " byte"}, bus_out, b);
            chk(mem_oe == 1'b0, "R7 oe off while injecting", mem_oe, 0);
            chk(done == 1'b0, "R10 no early done", done, 0);
            @(negedge clk);
            chk(bus_out == b, "R11 byte held between falls", bus_out, b);
        end
        if (op != 2'd2) begin
            fall_step();
            if (op == 2'd0) begin
                chk(bus_drive == 1'b0, "R3 released on store cycle", bus_drive, 0);
                chk(mem_oe == 1'b0, "R3 oe off on store cycle", mem_oe, 0);
            end else begin
                chk(bus_drive == 1'b0, "R4 released on load cycle", bus_drive, 0);
                chk(mem_oe == 1'b1, "R4 oe on load cycle", mem_oe, 1);
            end
        end
        fall_step();
        if (op == 2'd1) exp_rd = rv;
        chk(done == 1'b1, "R10 done at final fall", done, 1);
        chk(cmd_ready == 1'b1, "R10 ready with done", cmd_ready, 1);
        chk(bus_drive == 1'b0 && mem_oe == 1'b0, "R6 bus released at end",
            {bus_drive, mem_oe}, 0);
        chk(rdata == exp_rd, "R5 read capture/hold", rdata, exp_rd);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one clock", done, 0);
        if (poke) begin
            fall_step();
            fall_step();
            chk(bus_drive == 1'b0 && cmd_ready == 1'b1, "R8 busy command dropped",
                {bus_drive, cmd_ready}, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(bus_drive == 1'b0, "R1 drive after reset", bus_drive, 0);
        chk(mem_oe == 1'b0, "R1 oe after reset", mem_oe, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
        chk(rdata == 8'h00 && bus_out == 8'h00, "R1 data after reset", {rdata, bus_out}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_op(2'd0, 16'h3456, 8'h12, 8'h00, 0);
        do_op(2'd1, 16'h1234, 8'h00, 8'hC3, 1);
        do_op(2'd0, 16'hD000, 8'hFF, 8'h00, 0);
        chk(rdata == 8'hC3, "R5 rdata kept across write", rdata, 8'hC3);
        do_op(2'd1, 16'hFFFF, 8'h00, 8'h7E, 0);
        do_op(2'd1, 16'h00FF, 8'h00, 8'h00, 0);
        do_op(2'd2, 16'h8000, 8'h00, 8'h00, 0);

        // R9: unused operation code
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_addr = 16'hABCD;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b1, "R9 still idle", cmd_ready, 1);
        fall_step();
        fall_step();
        chk(bus_drive == 1'b0 && mem_oe == 1'b0 && done == 1'b0, "R9 nothing driven",
            {bus_drive, mem_oe, done}, 0);

        do_op(2'd2, 16'hFFFC, 8'h00, 8'h00, 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule